// File: doc/BRIEF.md
# Idle and Power-Down Clock Controller

This block holds the power-mode control register of a small microcontroller core and turns its contents into clock enables. Software writes one byte at a fixed special-function address. Two of its bits select a low-power mode. In idle, only the processor clock stops, and the timer, serial and interrupt logic keep their clock. In power-down, the oscillator enable drops, so every clock stops. The same register also holds a baud-rate doubling bit and two general-purpose flags, which software uses to record its own state across an idle period.

Idle ends in two ways: when any enabled interrupt arrives, hardware clears the idle bit, and an external reset also ends it. Power-down ends only on the external reset. The external reset pin first passes through a single synchroniser stage. It then counts as a reset only after the synchronised level has been seen high on a fixed number of consecutive oscillator edges. The block also tells the pin logic to hold the address-latch and program-strobe outputs: high during idle and low during power-down.

Top module: `pwr_clk_ctl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the register returns to its reset state. After that edge: `pcon_rd` = 0x00, all three clock enables = 1, `strobe_hold` = 0 and `strobe_level` = 1.
- R2: A write (`wr_en`=1) with `wr_addr` equal to 0x87 stores bits 7, 3, 2, 1 and 0 of `wr_data`. Bits 6 to 4 always read back as 0. A write to any other address changes nothing.
- R3: Idle mode is `pcon_rd[0]`=1 with `pcon_rd[1]`=0. In idle, `cpu_clk_en`=0, `per_clk_en`=1, `osc_en`=1, `strobe_hold`=1 and `strobe_level`=1. These values appear right after the edge that stores the bit.
- R4: Power-down mode is `pcon_rd[1]`=1. In power-down, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0, `strobe_hold`=1 and `strobe_level`=0.
- R5: A write with both `wr_data[1]` and `wr_data[0]` set enters power-down only. The readback then shows bit 1 = 1 and bit 0 = 0.
- R6: If `irq_req` is high at a rising edge during idle, that edge clears bit 0 and restores `cpu_clk_en`. All other register bits stay unchanged.
- R7: In power-down, `irq_req` has no effect. The register and the enables stay as they were.
- R8: After `ext_rst` rises, the register returns to 0x00 on the 25th rising edge: one synchroniser edge plus 24 consecutive high samples. This ends both idle and power-down. If `ext_rst` falls before the count completes, the register is left unchanged.
- R9: A register write is ignored while the block is in idle or power-down, because the processor is not clocked then.
- R10: The doubling bit (bit 7) and the flags (bits 3 and 2) keep their values when a mode is entered or left. Only R1, R2 and R8 change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock (oscillator rate) |
| rst_n | input | 1 | Synchronous active-low block reset |
| ext_rst | input | 1 | External reset pin, active high, asynchronous |
| wr_en | input | 1 | Special-function register write strobe |
| wr_addr | input | 8 | Special-function register write address |
| wr_data | input | 8 | Write data |
| irq_req | input | 1 | Any enabled interrupt is requesting service |
| pcon_rd | output | 8 | Register readback |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Timer, serial and interrupt clock enable |
| osc_en | output | 1 | Oscillator enable |
| strobe_hold | output | 1 | Force the address-latch and program-strobe pins |
| strobe_level | output | 1 | Level those pins take while forced |

## Verification
The bench builds the block with its defaults: register address 0x87 and a hold count of 24. This means the reset qualifier is tested at its real length. The bench checks one edge before and one edge after recognition, so an off-by-one in the synchroniser or the counter becomes visible. With the real address, a write to a neighbouring address shows that address decoding works. The vector table walks through the sequence run, idle, interrupt wake-up and power-down. The directed part then covers reset qualification from both low-power modes and from an interrupted pulse.

// File: rtl/pwr_pkg.sv
// Package: shared bit positions and the power mode type of the power
// control register. Assumes an 8-bit special-function register bus.
package pwr_pkg;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned BIT_DBL  = 7;   // baud doubling
    localparam int unsigned BIT_FLG1 = 3;   // general flag 1
    localparam int unsigned BIT_FLG0 = 2;   // general flag 0
    localparam int unsigned BIT_DOWN = 1;   // power-down request
    localparam int unsigned BIT_IDLE = 0;   // idle request
    localparam logic [REG_W-1:0] STORE_MASK = 8'h8F;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_DOWN = 2'd2
    } pm_mode_t;
endpackage

// File: rtl/rst_qualifier.sv
// Module: synchronises the external reset pin and asserts hw_rst only once
// the synchronised level has been high on HOLD consecutive edges.
// Assumes clk keeps running in power-down (always-on reference).
module rst_qualifier #(
    parameter int unsigned HOLD = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_rst,
    output logic hw_rst
);
    localparam int unsigned CNT_W = $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HOLD - 1);

    logic             sync_q;
    logic [CNT_W-1:0] cnt_q;

    // Purpose: one synchroniser stage for the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= pin_rst;
    end

    // Purpose: count consecutive high samples, saturate at HOLD-1.
    always_ff @(posedge clk) begin
        if (!rst_n || !sync_q)  cnt_q <= '0;
        else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
    end

    // Purpose: the HOLD-th consecutive sample is the one that resets.
    always_comb hw_rst = sync_q && (cnt_q == CNT_TOP);
endmodule

// File: rtl/pcon_reg.sv
// Module: power control register. Stores software writes, applies the
// power-down-over-idle precedence and the hardware idle clear on wake-up.
// Assumes writes come from the processor and so are dropped in low power.
module pcon_reg
    import pwr_pkg::*;
#(
    parameter logic [7:0] REG_ADDR = 8'h87
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             wake_req,
    output logic [REG_W-1:0] q
);
    logic             low_pwr;
    logic             hit;
    logic [REG_W-1:0] wr_val;

    // Purpose: decode a usable write and shape the stored value.
    always_comb begin
        low_pwr = q[BIT_DOWN] | q[BIT_IDLE];
        hit     = wr_en && (wr_addr == REG_ADDR) && !low_pwr;
        wr_val  = wr_data & STORE_MASK;
        if (wr_val[BIT_DOWN]) wr_val[BIT_IDLE] = 1'b0;
    end

    // Purpose: register update with reset, write and wake-up.
    always_ff @(posedge clk) begin
        if (!rst_n || hw_rst) begin
            q <= '0;
        end else if (hit) begin
            q <= wr_val;
        end else if (wake_req && q[BIT_IDLE] && !q[BIT_DOWN]) begin
            q[BIT_IDLE] <= 1'b0;
        end
    end
endmodule

// File: rtl/clk_gate_ctl.sv
// Module: decodes the register mode bits into clock enables and the
// strobe-pin hold controls. Purely combinational.
module clk_gate_ctl
    import pwr_pkg::*;
(
    input  logic down_bit,
    input  logic idle_bit,
    output logic cpu_en,
    output logic per_en,
    output logic osc_en,
    output logic hold,
    output logic level
);
    pm_mode_t mode;

    // Purpose: power-down outranks idle.
    always_comb begin
        if (down_bit)      mode = PM_DOWN;
        else if (idle_bit) mode = PM_IDLE;
        else               mode = PM_RUN;
    end

    // Purpose: per-mode output table.
    always_comb begin
        case (mode)
            PM_IDLE: {cpu_en, per_en, osc_en, hold, level} = 5'b01111;
            PM_DOWN: {cpu_en, per_en, osc_en, hold, level} = 5'b00010;
            default: {cpu_en, per_en, osc_en, hold, level} = 5'b11101;
        endcase
    end
endmodule

// File: rtl/pwr_clk_ctl.sv
// Module: top of the idle and power-down clock controller. Connects the
// reset qualifier, the control register and the gating decode.
module pwr_clk_ctl
    import pwr_pkg::*;
#(
    parameter logic [7:0]  REG_ADDR = 8'h87,
    parameter int unsigned RST_HOLD = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_rst,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       irq_req,
    output logic [7:0] pcon_rd,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       strobe_hold,
    output logic       strobe_level
);
    logic hw_rst;

    rst_qualifier #(.HOLD(RST_HOLD)) u_rstq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_rst (ext_rst),
        .hw_rst  (hw_rst)
    );

    pcon_reg #(.REG_ADDR(REG_ADDR)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_rst   (hw_rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wake_req (irq_req),
        .q        (pcon_rd)
    );

    clk_gate_ctl u_gate (
        .down_bit (pcon_rd[BIT_DOWN]),
        .idle_bit (pcon_rd[BIT_IDLE]),
        .cpu_en   (cpu_clk_en),
        .per_en   (per_clk_en),
        .osc_en   (osc_en),
        .hold     (strobe_hold),
        .level    (strobe_level)
    );
endmodule

// File: rtl/pwr_clk_ctl_chk.sv
// Checker: temporal properties of the clock controller, bound to the top.
module pwr_clk_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ext_rst,
    input logic       wr_en,
    input logic       irq_req,
    input logic [7:0] pcon_rd,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       osc_en,
    input logic       strobe_hold,
    input logic       strobe_level
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pcon_rd == 8'h00) && cpu_clk_en && osc_en);

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pcon_rd[6:4] == 3'b000);

    assert_idle_gating_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pcon_rd[0] && !pcon_rd[1]) |-> !cpu_clk_en && per_clk_en && osc_en
                                        && strobe_hold && strobe_level);

    assert_down_gating_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pcon_rd[1] |-> !cpu_clk_en && !per_clk_en && !osc_en
                       && strobe_hold && !strobe_level);

    assert_one_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pcon_rd[1] && pcon_rd[0]));

    assert_wake_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pcon_rd[0] && irq_req && !ext_rst && !$past(ext_rst))
        |=> !pcon_rd[0] && cpu_clk_en && (pcon_rd[7:1] == $past(pcon_rd[7:1])));

    assert_down_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pcon_rd[1] && !ext_rst && !$past(ext_rst)) |=> $stable(pcon_rd));

    assert_lowpwr_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pcon_rd[1:0] != 2'b00) && wr_en && !ext_rst && !$past(ext_rst))
        |=> pcon_rd[7:2] == $past(pcon_rd[7:2]));
endmodule

bind pwr_clk_ctl pwr_clk_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_rst      (ext_rst),
    .wr_en        (wr_en),
    .irq_req      (irq_req),
    .pcon_rd      (pcon_rd),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .osc_en       (osc_en),
    .strobe_hold  (strobe_hold),
    .strobe_level (strobe_level)
);

// File: tb/test_pwr_clk_ctl.sv
// Bench: vector table walk, then directed reset and corner tests.
module test_pwr_clk_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       irq_req = 1'b0;
    logic [7:0] pcon_rd;
    logic       cpu_clk_en, per_clk_en, osc_en, strobe_hold, strobe_level;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pwr_clk_ctl i_pwr_clk_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_rst      (ext_rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .irq_req      (irq_req),
        .pcon_rd      (pcon_rd),
        .cpu_clk_en   (cpu_clk_en),
        .per_clk_en   (per_clk_en),
        .osc_en       (osc_en),
        .strobe_hold  (strobe_hold),
        .strobe_level (strobe_level)
    );

    // Enable field order: {cpu, per, osc, hold, level}
    localparam logic [4:0] EN_RUN  = 5'b11101;
    localparam logic [4:0] EN_IDLE = 5'b01111;
    localparam logic [4:0] EN_DOWN = 5'b00010;

    // Vector: {wr, addr[8], data[8], irq, exp_rd[8], exp_en[5]}
    localparam int NV = 9;
    localparam logic [30:0] VEC [NV] = '{
        {1'b1, 8'h87, 8'hF4, 1'b0, 8'h84, EN_RUN },  // R2 reserved bits drop
        {1'b1, 8'h55, 8'hFF, 1'b0, 8'h84, EN_RUN },  // R2 other address
        {1'b1, 8'h87, 8'h09, 1'b0, 8'h09, EN_IDLE},  // R3 enter idle
        {1'b1, 8'h87, 8'h02, 1'b0, 8'h09, EN_IDLE},  // R9 write in idle
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h08, EN_RUN },  // R6 R10 wake, flag kept
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h08, EN_RUN },  // R6 irq in run
        {1'b1, 8'h87, 8'h07, 1'b0, 8'h06, EN_DOWN},  // R5 R4 both bits
        {1'b0, 8'h00, 8'h00, 1'b1, 8'h06, EN_DOWN},  // R7 irq in down
        {1'b1, 8'h87, 8'h00, 1'b0, 8'h06, EN_DOWN}   // R9 write in down
    };

    task automatic check(input string req, input logic [7:0] er, input logic [4:0] ee);
        logic [12:0] act;
        act = {pcon_rd, cpu_clk_en, per_clk_en, osc_en, strobe_hold, strobe_level};
        n_chk++;
        if (act !== {er, ee}) begin
            n_bad++;
            $display("FAIL %s: actual rd=%h en=%b expected rd=%h en=%b",
                     req, act[12:5], act[4:0], er, ee);
        end
    endtask

    task automatic step(input logic w, input logic [7:0] a, input logic [7:0] d,
                        input logic irq);
        wr_en = w; wr_addr = a; wr_data = d; irq_req = irq;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; irq_req = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1", 8'h00, EN_RUN);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][30], VEC[i][29:22], VEC[i][21:14], VEC[i][13]);
            check($sformatf("vec%0d", i), VEC[i][12:5], VEC[i][4:0]);
        end

        // R8: exit power-down only after the full qualification count
        ext_rst = 1'b1;
        wait_edges(24);
        check("R8 edge24", 8'h06, EN_DOWN);
        wait_edges(1);
        check("R8 edge25", 8'h00, EN_RUN);
        ext_rst = 1'b0;
        wait_edges(2);

        // R8: short pulse in idle is not a reset
        step(1'b1, 8'h87, 8'h8D, 1'b0);
        check("R3 R10", 8'h8D, EN_IDLE);
        ext_rst = 1'b1;
        wait_edges(20);
        ext_rst = 1'b0;
        wait_edges(3);
        check("R8 short", 8'h8D, EN_IDLE);

        // R8: full reset also ends idle
        ext_rst = 1'b1;
        wait_edges(25);
        check("R8 idle exit", 8'h00, EN_RUN);
        ext_rst = 1'b0;
        wait_edges(2);

        // R1: block reset from power-down
        step(1'b1, 8'h87, 8'h86, 1'b0);
        check("R4", 8'h86, EN_DOWN);
        rst_n = 1'b0;
        wait_edges(1);
        check("R1 mid", 8'h00, EN_RUN);
        rst_n = 1'b1;
        wait_edges(1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule